// File: doc/BRIEF.md
# Open Bank and Row Tracker

This block remembers, for every bank behind every chip select of an SDRAM controller, whether a row is currently open in that bank and which row it is. The controller presents a decoded chip select, a bank address and a row address together with a latch strobe. Two cycles later the block reports whether the addressed bank is open and whether its open row equals the requested one. From these two flags the controller picks its path. A hit (open and same row) goes straight to the read or write. An open bank holding another row needs a precharge and then an activate. A closed bank needs only an activate.

The controller keeps the table current with three strobes, all applied to the entry chosen by the most recent latch. The open strobe follows an activate when rows are to be kept open and stores the latched row. The single-close strobe follows a precharge of one bank. The close-all strobe follows any command that shuts every bank: precharge-all, mode register load, initialization or refresh. A separate flag reports whether any bank anywhere is still open.

Top module: `orow_tracker`

## Requirements
- R1: An active-low asynchronous reset clears every entry and drives bank_is_open, row_matches and any_open low at once. The latched address is also cleared, so the latched target counts as having no chip select.
- R2: A lookup strobed with latch_en in cycle n shows its result on bank_is_open and row_matches in cycle n+2. In cycle n+1 the outputs still show the entry at the previously latched address.
- R3: mark_open marks the latched entry open and stores the latched row. A lookup of that entry with the same row then returns bank_is_open=1 and row_matches=1.
- R4: A lookup of an open entry with a different row returns bank_is_open=1 and row_matches=0.
- R5: A lookup of a closed entry returns bank_is_open=0 and row_matches=0. row_matches is never 1 while bank_is_open is 0.
- R6: mark_closed closes only the latched entry. Other banks of the same chip select and the entries of other chip selects keep their state and their rows.
- R7: close_all closes every entry of every chip select.
- R8: When mark_open and mark_closed are both high in one cycle, the entry ends closed. When close_all is high, mark_open has no effect.
- R9: any_open is the OR of all entry valid bits. It changes in the cycle after the strobe that changes the table.
- R10: cs_sel is one-hot, with bit k selecting chip select k. If several bits are set, the lowest set bit is used. If no bit is set, lookups report closed and mark_open and mark_closed have no effect.
- R11: Between latch strobes the latched address holds. Changes on cs_sel, bank_addr and row_addr while latch_en is low do not change which entry the strobes target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| latch_en | input | 1 | Captures cs_sel, bank_addr and row_addr |
| cs_sel | input | NUM_CS | Decoded chip select, one-hot |
| bank_addr | input | BA_W | Bank address |
| row_addr | input | ROW_W | Row address |
| mark_open | input | 1 | Mark the latched entry open with the latched row |
| mark_closed | input | 1 | Close the latched entry |
| close_all | input | 1 | Close every entry |
| bank_is_open | output | 1 | Latched entry is open (lookup result) |
| row_matches | output | 1 | Latched entry is open with the latched row |
| any_open | output | 1 | At least one entry is open |

## Verification
The hardest case to reach is an update arriving while a lookup is still in flight. In that case the cycle n+1 output must still reflect the old address, and the cycle n+2 output must reflect the updated table. The stimulus reaches this case by keeping a reference table and a reference latched address in the bench. Every lookup queues two expected items, one for each of the two cycles. The directed sequences cover collisions between set and clear, a close-all on top of a set, an empty chip select and a multi-bit chip select. A randomized phase then mixes lookups and strobes over a small pool of rows so that hits and misses occur often.

// File: rtl/orow_pkg.sv
package orow_pkg;

  // Index of the lowest set bit among the first n bits; -1 when none is set.
  function automatic int lowest_one(input logic [63:0] v, input int n);
    int idx;
    idx = -1;
    for (int i = n - 1; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

  // Flat table position of a (chip select, bank) pair.
  function automatic int entry_index(input int cs_idx, input int bank, input int nbanks);
    return cs_idx * nbanks + bank;
  endfunction

endpackage

// File: rtl/orow_addr_latch.sv
module orow_addr_latch #(
  parameter int NUM_CS = 8,
  parameter int BA_W   = 2,
  parameter int ROW_W  = 13,
  parameter int CS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [NUM_CS-1:0] cs_sel,
  input  logic [BA_W-1:0]   bank_addr,
  input  logic [ROW_W-1:0]  row_addr,
  output logic [CS_W-1:0]   lat_cs_idx,
  output logic              lat_cs_any,
  output logic [BA_W-1:0]   lat_bank,
  output logic [ROW_W-1:0]  lat_row
);
  import orow_pkg::*;

  int          pick;
  logic        pick_any;
  logic [CS_W-1:0] pick_idx;

  always_comb begin
    pick     = lowest_one(64'(cs_sel), NUM_CS);
    pick_any = (pick >= 0);
    pick_idx = pick_any ? CS_W'(pick) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_cs_idx <= '0;
      lat_cs_any <= 1'b0;
      lat_bank   <= '0;
      lat_row    <= '0;
    end else if (latch_en) begin
      lat_cs_idx <= pick_idx;
      lat_cs_any <= pick_any;
      lat_bank   <= bank_addr;
      lat_row    <= row_addr;
    end
  end

  // R11: latched address holds while no strobe is given
  p_hold_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_en |=> $stable(lat_bank) && $stable(lat_row) && $stable(lat_cs_any));

endmodule

// File: rtl/orow_bank_table.sv
module orow_bank_table #(
  parameter int NENT  = 32,
  parameter int ENT_W = 5,
  parameter int ROW_W = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ENT_W-1:0]           tgt,
  input  logic                       lat_cs_any,
  input  logic [ROW_W-1:0]           lat_row,
  input  logic                       mark_open,
  input  logic                       mark_closed,
  input  logic                       close_all,
  output logic [NENT-1:0]            valid_vec,
  output logic [NENT-1:0][ROW_W-1:0] tags
);

  logic [NENT-1:0] sel_entry;
  logic [NENT-1:0] wr_open;
  logic [NENT-1:0] wr_close;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic             v_q;
    logic [ROW_W-1:0] t_q;

    assign sel_entry[i] = lat_cs_any && (tgt == ENT_W'(i));
    assign wr_close[i]  = close_all || (sel_entry[i] && mark_closed);
    assign wr_open[i]   = sel_entry[i] && mark_open && !wr_close[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        t_q <= '0;
      end else if (wr_close[i]) begin
        v_q <= 1'b0;
      end else if (wr_open[i]) begin
        v_q <= 1'b1;
        t_q <= lat_row;
      end
    end

    assign valid_vec[i] = v_q;
    assign tags[i]      = t_q;
  end

  // R7: close_all empties the table
  p_clear_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |=> (valid_vec == '0));

  // R8: clear beats set on the same entry
  p_clear_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_open && mark_closed && lat_cs_any) |=> !valid_vec[$past(tgt)]);

  // R3: set records open with the latched row
  p_set_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_open && !mark_closed && !close_all && lat_cs_any)
      |=> valid_vec[$past(tgt)] && (tags[$past(tgt)] == $past(lat_row)));

  // R10: no chip select, no change
  p_no_cs_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_cs_any && !close_all) |=> $stable(valid_vec));

  // R6: a single close touches at most one entry
  p_single_clear_local_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mark_closed && !close_all && lat_cs_any)
      |=> $countones(valid_vec ^ $past(valid_vec)) <= 1);

endmodule

// File: rtl/orow_lookup.sv
module orow_lookup #(
  parameter int NENT  = 32,
  parameter int ENT_W = 5,
  parameter int ROW_W = 13
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NENT-1:0]            valid_vec,
  input  logic [NENT-1:0][ROW_W-1:0] tags,
  input  logic [ENT_W-1:0]           tgt,
  input  logic                       lat_cs_any,
  input  logic [ROW_W-1:0]           lat_row,
  output logic                       bank_is_open,
  output logic                       row_matches
);

  logic entry_open;
  logic entry_same;

  assign entry_open = lat_cs_any && valid_vec[tgt];
  assign entry_same = entry_open && (tags[tgt] == lat_row);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_is_open <= 1'b0;
      row_matches  <= 1'b0;
    end else begin
      bank_is_open <= entry_open;
      row_matches  <= entry_same;
    end
  end

  // R5: a row match implies an open bank
  p_same_needs_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    row_matches |-> bank_is_open);

  // R10: no chip select reports closed one cycle later
  p_no_cs_closed_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !lat_cs_any |=> !bank_is_open);

endmodule

// File: rtl/orow_tracker.sv
module orow_tracker #(
  parameter int NUM_CS    = 8,
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              latch_en,
  input  logic [NUM_CS-1:0] cs_sel,
  input  logic [BA_W-1:0]   bank_addr,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic              mark_open,
  input  logic              mark_closed,
  input  logic              close_all,
  output logic              bank_is_open,
  output logic              row_matches,
  output logic              any_open
);
  import orow_pkg::*;

  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;
  localparam int NENT  = NUM_CS * NUM_BANKS;
  localparam int ENT_W = (NENT > 1) ? $clog2(NENT) : 1;

  logic [CS_W-1:0]            lat_cs_idx;
  logic                       lat_cs_any;
  logic [BA_W-1:0]            lat_bank;
  logic [ROW_W-1:0]           lat_row;
  logic [ENT_W-1:0]           tgt;
  logic [NENT-1:0]            valid_vec;
  logic [NENT-1:0][ROW_W-1:0] tags;

  orow_addr_latch #(
    .NUM_CS(NUM_CS), .BA_W(BA_W), .ROW_W(ROW_W), .CS_W(CS_W)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en),
    .cs_sel(cs_sel), .bank_addr(bank_addr), .row_addr(row_addr),
    .lat_cs_idx(lat_cs_idx), .lat_cs_any(lat_cs_any),
    .lat_bank(lat_bank), .lat_row(lat_row)
  );

  assign tgt = ENT_W'(entry_index(int'(lat_cs_idx), int'(lat_bank), NUM_BANKS));

  orow_bank_table #(
    .NENT(NENT), .ENT_W(ENT_W), .ROW_W(ROW_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .lat_cs_any(lat_cs_any),
    .lat_row(lat_row), .mark_open(mark_open), .mark_closed(mark_closed),
    .close_all(close_all), .valid_vec(valid_vec), .tags(tags)
  );

  orow_lookup #(
    .NENT(NENT), .ENT_W(ENT_W), .ROW_W(ROW_W)
  ) u_lookup (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .tags(tags),
    .tgt(tgt), .lat_cs_any(lat_cs_any), .lat_row(lat_row),
    .bank_is_open(bank_is_open), .row_matches(row_matches)
  );

  assign any_open = |valid_vec;

  // R9: an open lookup result implies some bank was open a cycle earlier
  p_open_implies_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_is_open && !$past(close_all)) |-> $past(any_open));

endmodule

// File: tb/orow_tracker_test.sv
module orow_tracker_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCS = 8;
  localparam int NB  = 4;
  localparam int RW  = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic latch_en = 1'b0;
  logic [NCS-1:0] cs_sel = '0;
  logic [1:0] bank_addr = '0;
  logic [RW-1:0] row_addr = '0;
  logic mark_open = 1'b0, mark_closed = 1'b0, close_all = 1'b0;
  logic bank_is_open, row_matches, any_open;

  orow_tracker #(.NUM_CS(NCS), .NUM_BANKS(NB), .ROW_W(RW)) uut (
    .clk(clk), .rst_n(rst_n), .latch_en(latch_en), .cs_sel(cs_sel),
    .bank_addr(bank_addr), .row_addr(row_addr), .mark_open(mark_open),
    .mark_closed(mark_closed), .close_all(close_all),
    .bank_is_open(bank_is_open), .row_matches(row_matches), .any_open(any_open)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    due;
    bit    lk;
    bit    op;
    bit    sm;
    bit    an;
    string rq;
  } exp_t;
  exp_t sbq[$];

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model
  bit            mv [NCS][NB];
  logic [RW-1:0] mt [NCS][NB];
  int            lcs = -1;
  int            lb  = 0;
  logic [RW-1:0] lr  = '0;

  function automatic int pick_cs(logic [NCS-1:0] s);
    for (int i = 0; i < NCS; i++) if (s[i]) return i;
    return -1;
  endfunction
  function automatic bit m_open();
    return (lcs >= 0) && mv[lcs][lb];
  endfunction
  function automatic bit m_same();
    return m_open() && (mt[lcs][lb] == lr);
  endfunction
  function automatic bit m_any();
    bit a = 0;
    for (int c = 0; c < NCS; c++) for (int b = 0; b < NB; b++) a |= mv[c][b];
    return a;
  endfunction
  function automatic void m_wipe();
    for (int c = 0; c < NCS; c++) for (int b = 0; b < NB; b++) mv[c][b] = 0;
  endfunction

  task automatic chk(bit got, bit exp, string rq, string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s got=%0b exp=%0b (cycle %0d)", rq, what, got, exp, cyc);
    end
  endtask

  // monitor: pop and compare due items
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      if (e.due != cyc) begin
        checks++; fails++;
        $display("FAIL %s missed sample got=%0d exp=%0d", e.rq, cyc, e.due);
      end else begin
        if (e.lk) begin
          chk(bank_is_open, e.op, e.rq, "bank_is_open");
          chk(row_matches, e.sm, e.rq, "row_matches");
        end
        chk(any_open, e.an, e.rq, "any_open");
      end
    end
  end

  task automatic do_lookup(logic [NCS-1:0] s, int b, logic [RW-1:0] r, string rq);
    exp_t e;
    @(negedge clk);
    e.due = cyc + 1; e.lk = 1; e.op = m_open(); e.sm = m_same(); e.an = m_any();
    e.rq = {rq, " R2-hold"};
    sbq.push_back(e);
    cs_sel = s; bank_addr = 2'(b); row_addr = r; latch_en = 1'b1;
    lcs = pick_cs(s); lb = b; lr = r;
    e.due = cyc + 2; e.op = m_open(); e.sm = m_same(); e.an = m_any(); e.rq = rq;
    sbq.push_back(e);
    @(negedge clk);
    latch_en = 1'b0;
  endtask

  task automatic do_update(bit st, bit cl, bit all, string rq);
    exp_t e;
    @(negedge clk);
    mark_open = st; mark_closed = cl; close_all = all;
    if (all) m_wipe();
    else if (lcs >= 0) begin
      if (cl) mv[lcs][lb] = 0;
      else if (st) begin mv[lcs][lb] = 1; mt[lcs][lb] = lr; end
    end
    e.due = cyc + 1; e.lk = 0; e.op = 0; e.sm = 0; e.an = m_any(); e.rq = rq;
    sbq.push_back(e);
    @(negedge clk);
    mark_open = 1'b0; mark_closed = 1'b0; close_all = 1'b0;
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    m_wipe();
    repeat (3) @(negedge clk);
    // R1: outputs low in reset
    chk(bank_is_open, 0, "R1", "bank_is_open in reset");
    chk(row_matches, 0, "R1", "row_matches in reset");
    chk(any_open, 0, "R1", "any_open in reset");
    rst_n = 1'b1;

    // R5 closed, then R3 hit, R4 miss
    do_lookup(8'b0000_0001, 1, 13'd5, "R5 closed");
    do_update(1, 0, 0, "R9 set raises any");
    do_lookup(8'b0000_0001, 1, 13'd5, "R3 hit");
    do_lookup(8'b0000_0001, 1, 13'd6, "R4 miss");
    do_lookup(8'b0000_0001, 2, 13'd7, "R5 other bank closed");
    do_update(1, 0, 0, "R3 set bank2");
    do_lookup(8'b0000_0100, 3, 13'h1FFF, "R5 cs2 closed");
    do_update(1, 0, 0, "R3 set cs2 max row");
    do_lookup(8'b0000_0100, 3, 13'h1FFF, "R3 cs2 hit");
    // R6 single close
    do_lookup(8'b0000_0001, 1, 13'd5, "R3 hit again");
    do_update(0, 1, 0, "R6 single clear any stays");
    do_lookup(8'b0000_0001, 1, 13'd5, "R6 cleared entry closed");
    do_lookup(8'b0000_0001, 2, 13'd7, "R6 neighbour bank kept");
    do_lookup(8'b0000_0100, 3, 13'h1FFF, "R6 other cs kept");
    // R8 set+clear collision
    do_lookup(8'b0000_1000, 0, 13'd9, "R5 cs3 closed");
    do_update(1, 1, 0, "R8 set+clear");
    do_lookup(8'b0000_1000, 0, 13'd9, "R8 clear wins");
    // R8/R7 set + close_all
    do_update(1, 0, 1, "R7 close_all with set");
    do_lookup(8'b0000_1000, 0, 13'd9, "R8 close_all overrides set");
    do_lookup(8'b0000_0001, 2, 13'd7, "R7 bank2 closed");
    do_lookup(8'b0000_0100, 3, 13'h1FFF, "R7 cs2 closed");
    // R10 empty chip select
    do_lookup(8'b0000_0000, 1, 13'd4, "R10 no cs closed");
    do_update(1, 0, 0, "R10 set ignored");
    do_lookup(8'b0000_0000, 1, 13'd4, "R10 no cs still closed");
    // R10 multi-bit chip select picks lowest
    do_lookup(8'b1010_0000, 2, 13'd33, "R10 multi cs closed");
    do_update(1, 0, 0, "R10 multi cs set");
    do_lookup(8'b0010_0000, 2, 13'd33, "R10 lowest bit chosen");
    do_lookup(8'b1000_0000, 2, 13'd33, "R10 upper bit untouched");
    // R11 address changes without latch are ignored
    do_lookup(8'b0000_0010, 0, 13'd11, "R5 cs1 closed");
    @(negedge clk);
    cs_sel = 8'b0100_0000; bank_addr = 2'd3; row_addr = 13'd99;
    do_update(1, 0, 0, "R11 set targets latched");
    do_lookup(8'b0000_0010, 0, 13'd11, "R11 latched entry opened");
    do_lookup(8'b0100_0000, 3, 13'd99, "R11 unlatched entry closed");
    drain();

    // R1 asynchronous reset mid-run
    @(negedge clk);
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk(any_open, 0, "R1", "any_open async reset");
    chk(bank_is_open, 0, "R1", "bank_is_open async reset");
    m_wipe(); lcs = -1; lb = 0; lr = '0;
    @(negedge clk);
    rst_n = 1'b1;
    do_lookup(8'b0000_0010, 0, 13'd11, "R1 table empty after reset");

    // randomized mix
    for (int k = 0; k < 80; k++) begin
      int sel;
      logic [RW-1:0] rr;
      sel = $urandom_range(0, 9);
      rr  = ($urandom_range(0, 2) == 0) ? 13'h1FFF : RW'($urandom_range(0, 2));
      if (sel < 5) begin
        logic [NCS-1:0] s;
        s = ($urandom_range(0, 7) == 0) ? '0 : NCS'(1) << $urandom_range(0, NCS-1);
        do_lookup(s, $urandom_range(0, NB-1), rr, "R2 random lookup");
      end else if (sel < 8) do_update(1, 0, 0, "R3 random set");
      else if (sel < 9) do_update(0, 1, 0, "R6 random clear");
      else do_update($urandom_range(0, 1), 0, 1, "R7 random close_all");
    end
    drain();

    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired got=%0d exp=done", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule